// File: doc/BRIEF.md
# I2C Master Bit-Level Engine

This block produces the low-level waveforms of an I2C master on an open-drain bus. A higher-level transaction sequencer gives it one command at a time: bus recovery, START condition, STOP condition, byte write with acknowledge sampling, or byte read with a chosen acknowledge level. The engine turns each command into a fixed sequence of SCL and SDA changes. It raises `done` for one cycle when the command has finished. It returns the received byte and the sampled acknowledge bit.

All timing comes from a delay tick. A prescaler counter produces one tick every `prescale + 1` clock cycles. The prescaler value is captured when a command is accepted, so each command runs at one rate. Every bus phase lasts one or two ticks, so the length of each command is a fixed number of ticks. SDA is modelled as a drive-low enable. The engine holds a data level and a separate driver enable, and pulls the wire low only when the driver is enabled and the level is 0. SCL is a plain level output. The engine has no clock stretching, no arbitration and no addressing.

Top module: `i2c_bit_engine`

## Requirements
- R1: After reset, `sclOut` is 1, `sdaDriveLow` is 0, `cmdReady` is 1, `done` is 0 and `ackBit` is 1.
- R2: A command is accepted on a clock edge where `cmdValid` and `cmdReady` are both high. `cmdReady` is low from the cycle after acceptance until the command ends. The command ends with a `done` pulse that lasts exactly one cycle, in the cycle after tick number T, where T is the command's tick count. `cmdReady` is high while `done` is high.
- R3: START (`cmdOp` = 1) takes 4 ticks. SDA is released and SCL is raised. SDA then falls while SCL is high, and both lines stay in that state (SCL 1, SDA 0) at the end.
- R4: STOP (`cmdOp` = 2) takes 4 ticks. SCL goes low, then SDA is pulled low. SCL then rises, and SDA rises while SCL is high. The SDA driver is disabled at the end, so `sdaDriveLow` is 0 and SCL is 1.
- R5: Write (`cmdOp` = 3) takes 37 ticks. It shifts `cmdData` out most significant bit first. Each bit is valid on the bus at its SCL rising edge, and each SCL high phase lasts 2 ticks.
- R6: After the 8 data bits of a write, the master releases SDA for a ninth SCL pulse. It samples the bus at the end of that pulse. `ackBit` becomes 0 if a target holds SDA low, and 1 otherwise.
- R7: Read (`cmdOp` = 4) takes 29 ticks. The master does not pull SDA during the 8 data clocks. It samples SDA one tick after each SCL rise, most significant bit first, into `rxByte`.
- R8: On the ninth clock of a read, the master drives the `cmdAck` level that was captured at acceptance: 0 pulls SDA low and 1 releases it. The SCL high phase of this clock lasts 2 ticks.
- R9: Bus reset (`cmdOp` = 0) takes 40 ticks. It gives nine SCL pulses, with 2-tick low and 2-tick high phases, while the master keeps SDA released. It then runs the full STOP sequence and ends with SDA tristated.
- R10: One tick is `prescale + 1` clock cycles. `prescale` is captured when a command is accepted, and changing the input later does not alter the running command.
- R11: `rxByte` and `ackBit` keep their values while no read or write is running.
- R12: An undefined opcode (5 to 7) is accepted, leaves the bus untouched and raises `done` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| prescale | input | PRESC_W | Tick period minus one, captured at acceptance |
| cmdValid | input | 1 | Command request |
| cmdReady | output | 1 | Engine idle, can accept a command |
| cmdOp | input | 3 | 0 reset, 1 start, 2 stop, 3 write, 4 read |
| cmdData | input | DATA_W | Byte to write |
| cmdAck | input | 1 | Acknowledge level to send after a read |
| done | output | 1 | One-cycle completion pulse |
| rxByte | output | DATA_W | Last received byte |
| ackBit | output | 1 | Last sampled acknowledge (0 = ACK) |
| sclOut | output | 1 | SCL level |
| sdaDriveLow | output | 1 | 1 pulls SDA low, 0 releases it |
| sdaIn | input | 1 | Resolved SDA level on the bus |

## Verification
A wrong state step or a wrong tick count shows up at once as a changed command length. It also shows up as a missing or extra SCL rising edge on the bus, and both can be seen within one command. A bit counter off by one changes the byte captured on SDA or the number of reset pulses. A wrong driver enable pulls SDA during an acknowledge or read slot. That shows up as a wrong `ackBit` or a wrong `rxByte` when `done` rises. A prescaler that is not captured, or that is miscounted, changes the measured SCL high-phase width and the command length within the same command.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

  localparam logic [2:0] OP_RESET = 3'd0;
  localparam logic [2:0] OP_START = 3'd1;
  localparam logic [2:0] OP_STOP  = 3'd2;
  localparam logic [2:0] OP_WRITE = 3'd3;
  localparam logic [2:0] OP_READ  = 3'd4;

  typedef enum logic [4:0] {
    S_IDLE,
    S_RST_LO, S_RST_HI,
    S_ST_A, S_ST_B, S_ST_C, S_ST_D,
    S_SP_A, S_SP_B, S_SP_C, S_SP_D,
    S_WB_LO, S_WB_SET, S_WB_HI,
    S_WA_LO, S_WA_REL, S_WA_HI, S_WA_END,
    S_RB_LO, S_RB_HI1, S_RB_HI2,
    S_RA_LO, S_RA_SET, S_RA_HI, S_RA_END
  } eng_state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic tickClr;
    logic prescLoad;
    logic sclSet;
    logic sclVal;
    logic sdaSet;
    logic sdaVal;
    logic sdaFromTx;
    logic enSet;
    logic enVal;
    logic txLoad;
    logic txShift;
    logic rxSample;
    logic ackSample;
    logic busy;
  } eng_strobe_t;

  // Phases that last two ticks; all others last one
  function automatic logic twoTick(eng_state_e s);
    return (s == S_RST_LO) || (s == S_RST_HI) || (s == S_WB_HI) ||
           (s == S_WA_HI)  || (s == S_RA_HI);
  endfunction

endpackage

// File: rtl/i2c_eng_ctrl.sv
module i2c_eng_ctrl
  import i2c_eng_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int RST_PULSES = 9
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [2:0]  cmdOp,
  input  logic        cmdAck,
  input  logic        tick,
  output logic        cmdReady,
  output logic        done,
  output eng_strobe_t strobe
);

  localparam int MAX_CNT = (DATA_W > RST_PULSES) ? DATA_W : RST_PULSES;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] LAST_BIT   = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_PULSE = CNT_W'(RST_PULSES - 1);

  eng_state_e       state, advTarget, firstState;
  logic             waitCnt;
  logic [CNT_W-1:0] bitCnt;
  logic             ackLevel;
  logic             accept, lastTick, busy;

  assign busy     = (state != S_IDLE);
  assign cmdReady = !busy;
  assign accept   = cmdValid && !busy;
  assign lastTick = busy && tick && (waitCnt == twoTick(state));

  // Actions applied on entering a phase
  function automatic eng_strobe_t withEntry(eng_strobe_t s, eng_state_e n, logic lvl);
    eng_strobe_t r;
    r = s;
    case (n)
      S_RST_LO, S_SP_A, S_WB_LO, S_WA_LO, S_WA_END, S_RB_LO, S_RA_LO, S_RA_END: begin
        r.sclSet = 1'b1; r.sclVal = 1'b0;
      end
      S_RST_HI, S_SP_C, S_ST_C, S_WB_HI, S_WA_HI, S_RB_HI1, S_RA_HI: begin
        r.sclSet = 1'b1; r.sclVal = 1'b1;
      end
      S_SP_B, S_ST_D: begin
        r.sdaSet = 1'b1; r.sdaVal = 1'b0;
        r.enSet  = (n == S_SP_B); r.enVal = 1'b1;
      end
      S_SP_D: begin
        r.sdaSet = 1'b1; r.sdaVal = 1'b1;
      end
      S_ST_B: begin
        r.sdaSet = 1'b1; r.sdaVal = 1'b1; r.enSet = 1'b1; r.enVal = 1'b1;
      end
      S_WB_SET: r.sdaFromTx = 1'b1;
      S_WA_REL: begin
        r.sdaSet = 1'b1; r.sdaVal = 1'b1; r.enSet = 1'b1; r.enVal = 1'b0;
      end
      S_RA_SET: begin
        r.sdaSet = 1'b1; r.sdaVal = lvl; r.enSet = 1'b1; r.enVal = 1'b1;
      end
      default: ;
    endcase
    return r;
  endfunction

  // Actions applied on leaving a phase
  function automatic eng_strobe_t withExit(eng_strobe_t s, eng_state_e c);
    eng_strobe_t r;
    r = s;
    case (c)
      S_WB_HI:  r.txShift   = 1'b1;
      S_WA_HI:  r.ackSample = 1'b1;
      S_RB_HI1: r.rxSample  = 1'b1;
      S_WA_END: begin r.enSet = 1'b1; r.enVal = 1'b1; end
      S_SP_D:   begin r.enSet = 1'b1; r.enVal = 1'b0; end
      default: ;
    endcase
    return r;
  endfunction

  always_comb begin
    case (cmdOp)
      OP_RESET: firstState = S_RST_LO;
      OP_START: firstState = S_ST_A;
      OP_STOP:  firstState = S_SP_A;
      OP_WRITE: firstState = S_WB_LO;
      OP_READ:  firstState = S_RB_LO;
      default:  firstState = S_IDLE;
    endcase
  end

  always_comb begin
    case (state)
      S_RST_LO: advTarget = S_RST_HI;
      S_RST_HI: advTarget = (bitCnt == LAST_PULSE) ? S_SP_A : S_RST_LO;
      S_ST_A:   advTarget = S_ST_B;
      S_ST_B:   advTarget = S_ST_C;
      S_ST_C:   advTarget = S_ST_D;
      S_SP_A:   advTarget = S_SP_B;
      S_SP_B:   advTarget = S_SP_C;
      S_SP_C:   advTarget = S_SP_D;
      S_WB_LO:  advTarget = S_WB_SET;
      S_WB_SET: advTarget = S_WB_HI;
      S_WB_HI:  advTarget = (bitCnt == LAST_BIT) ? S_WA_LO : S_WB_LO;
      S_WA_LO:  advTarget = S_WA_REL;
      S_WA_REL: advTarget = S_WA_HI;
      S_WA_HI:  advTarget = S_WA_END;
      S_RB_LO:  advTarget = S_RB_HI1;
      S_RB_HI1: advTarget = S_RB_HI2;
      S_RB_HI2: advTarget = (bitCnt == LAST_BIT) ? S_RA_LO : S_RB_LO;
      S_RA_LO:  advTarget = S_RA_SET;
      S_RA_SET: advTarget = S_RA_HI;
      S_RA_HI:  advTarget = S_RA_END;
      default:  advTarget = S_IDLE;
    endcase
  end

  always_comb begin
    strobe      = '0;
    strobe.busy = busy;
    if (accept) begin
      strobe.tickClr   = 1'b1;
      strobe.prescLoad = 1'b1;
      case (cmdOp)
        OP_RESET, OP_READ: begin
          strobe.sdaSet = 1'b1; strobe.sdaVal = 1'b1;
          strobe.enSet  = 1'b1; strobe.enVal  = 1'b0;
        end
        OP_WRITE: begin
          strobe.txLoad = 1'b1;
          strobe.enSet  = 1'b1; strobe.enVal = 1'b1;
        end
        default: ;
      endcase
      strobe = withEntry(strobe, firstState, cmdAck);
    end else if (lastTick) begin
      strobe = withExit(strobe, state);
      strobe = withEntry(strobe, advTarget, ackLevel);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      waitCnt  <= 1'b0;
      bitCnt   <= '0;
      ackLevel <= 1'b1;
      done     <= 1'b0;
    end else begin
      done <= (accept && (firstState == S_IDLE)) ||
              (lastTick && (advTarget == S_IDLE));
      if (accept) begin
        state    <= firstState;
        waitCnt  <= 1'b0;
        bitCnt   <= '0;
        ackLevel <= cmdAck;
      end else if (busy && tick) begin
        waitCnt <= lastTick ? 1'b0 : 1'b1;
        if (lastTick) begin
          state <= advTarget;
          if ((state == S_RST_HI) || (state == S_WB_HI) || (state == S_RB_HI2))
            bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  // R2: completion only ever reported with the engine idle
  p_done_ready_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> cmdReady);

  // R2: a defined command makes the engine busy on the next cycle
  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && (cmdOp <= OP_READ)) |=> !cmdReady);

  // R12: an undefined opcode completes immediately
  p_nop_done_r12: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && (cmdOp > OP_READ)) |=> (done && cmdReady));

endmodule

// File: rtl/i2c_eng_dp.sv
module i2c_eng_dp
  import i2c_eng_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int PRESC_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  eng_strobe_t        strobe,
  input  logic [PRESC_W-1:0] prescale,
  input  logic [DATA_W-1:0]  txData,
  input  logic               sdaIn,
  output logic               tick,
  output logic               sclOut,
  output logic               sdaDriveLow,
  output logic [DATA_W-1:0]  rxByte,
  output logic               ackBit
);

  logic [PRESC_W-1:0] prescReg, tickCnt;
  logic [DATA_W-1:0]  txReg, rxReg;
  logic               sclReg, sdaLevel, sdaEn, ackReg;

  assign tick        = strobe.busy && (tickCnt == prescReg);
  assign sclOut      = sclReg;
  assign sdaDriveLow = sdaEn && !sdaLevel;
  assign rxByte      = rxReg;
  assign ackBit      = ackReg;

  // Tick prescaler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescReg <= '0;
      tickCnt  <= '0;
    end else begin
      if (strobe.prescLoad) prescReg <= prescale;
      if (strobe.tickClr)   tickCnt  <= '0;
      else if (strobe.busy) tickCnt  <= tick ? '0 : tickCnt + 1'b1;
    end
  end

  // Bus line state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclReg   <= 1'b1;
      sdaLevel <= 1'b1;
      sdaEn    <= 1'b0;
    end else begin
      if (strobe.sclSet) sclReg <= strobe.sclVal;
      if (strobe.sdaFromTx)   sdaLevel <= txReg[DATA_W-1];
      else if (strobe.sdaSet) sdaLevel <= strobe.sdaVal;
      if (strobe.enSet) sdaEn <= strobe.enVal;
    end
  end

  // Shift registers and acknowledge capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg  <= '0;
      rxReg  <= '0;
      ackReg <= 1'b1;
    end else begin
      if (strobe.txLoad)       txReg <= txData;
      else if (strobe.txShift) txReg <= {txReg[DATA_W-2:0], 1'b0};
      if (strobe.rxSample)  rxReg  <= {rxReg[DATA_W-2:0], sdaIn};
      if (strobe.ackSample) ackReg <= sdaIn;
    end
  end

  // R6: master never pulls SDA while sampling acknowledge
  p_ack_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ackSample |-> !sdaDriveLow);

  // R7: master never pulls SDA while sampling read data
  p_rx_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rxSample |-> !sdaDriveLow);

  // R10: with a nonzero prescale, ticks are never adjacent
  p_tick_gap_r10: assert property (@(posedge clk) disable iff (!rstN)
    (tick && (prescReg != '0) && !strobe.tickClr) |=> !tick);

  // R11: results hold while nothing runs
  p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.busy && !strobe.prescLoad) |=> ($stable(rxByte) && $stable(ackBit)));

endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_eng_pkg::*;
#(
  parameter int PRESC_W    = 16,
  parameter int DATA_W     = 8,
  parameter int RST_PULSES = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PRESC_W-1:0] prescale,
  input  logic               cmdValid,
  output logic               cmdReady,
  input  logic [2:0]         cmdOp,
  input  logic [DATA_W-1:0]  cmdData,
  input  logic               cmdAck,
  output logic               done,
  output logic [DATA_W-1:0]  rxByte,
  output logic               ackBit,
  output logic               sclOut,
  output logic               sdaDriveLow,
  input  logic               sdaIn
);

  eng_strobe_t strobe;
  logic        tick;

  i2c_eng_ctrl #(.DATA_W(DATA_W), .RST_PULSES(RST_PULSES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .cmdAck   (cmdAck),
    .tick     (tick),
    .cmdReady (cmdReady),
    .done     (done),
    .strobe   (strobe)
  );

  i2c_eng_dp #(.DATA_W(DATA_W), .PRESC_W(PRESC_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .prescale    (prescale),
    .txData      (cmdData),
    .sdaIn       (sdaIn),
    .tick        (tick),
    .sclOut      (sclOut),
    .sdaDriveLow (sdaDriveLow),
    .rxByte      (rxByte),
    .ackBit      (ackBit)
  );

endmodule

// File: tb/i2c_bit_engine_bench.sv
module i2c_bit_engine_bench;

  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [PW-1:0] prescale = '0;
  logic          cmdValid = 1'b0;
  logic          cmdReady;
  logic [2:0]    cmdOp = '0;
  logic [7:0]    cmdData = '0;
  logic          cmdAck = 1'b0;
  logic          done;
  logic [7:0]    rxByte;
  logic          ackBit;
  logic          sclOut;
  logic          sdaDriveLow;
  logic          sdaBus;
  logic          slaveLow = 1'b0;

  assign sdaBus = ~(sdaDriveLow | slaveLow);

  always #2.5 clk = ~clk;

  i2c_bit_engine u_i2c_bit_engine (
    .clk(clk), .rstN(rstN), .prescale(prescale), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .cmdOp(cmdOp), .cmdData(cmdData), .cmdAck(cmdAck),
    .done(done), .rxByte(rxByte), .ackBit(ackBit), .sclOut(sclOut),
    .sdaDriveLow(sdaDriveLow), .sdaIn(sdaBus)
  );

  int checks = 0;
  int fails = 0;

  // Bus monitor
  int          rises = 0;
  int          base = 0;
  logic [15:0] capShift = '0;
  int          starts = 0;
  int          stops = 0;
  int          hiRun = 0;
  int          lastHi = 0;
  int          slaveMode = 0;   // 0 idle, 1 write ack, 2 read data
  logic        slaveAckEn = 1'b0;
  logic [7:0]  slaveData = '0;

  always @(posedge sclOut) begin
    capShift = {capShift[14:0], sdaBus};
    rises = rises + 1;
  end

  always @(negedge sdaBus) if (sclOut === 1'b1) starts = starts + 1;
  always @(posedge sdaBus) if (sclOut === 1'b1) stops = stops + 1;

  always @(negedge clk) begin
    if (sclOut === 1'b1) hiRun = hiRun + 1;
    else begin
      if (hiRun != 0) lastHi = hiRun;
      hiRun = 0;
    end
  end

  // Target model: acknowledges writes, returns read data
  always @(negedge sclOut) begin : slv
    int k;
    k = rises - base;
    if (slaveMode == 1) begin
      if (k == 8) slaveLow = slaveAckEn;
      else if (k == 9) slaveLow = 1'b0;
    end else if (slaveMode == 2) begin
      if (k >= 1 && k < 8) slaveLow = ~slaveData[7-k];
      else if (k == 8) slaveLow = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Issue one command; returns cycles from acceptance to done
  task automatic issueCmd(input logic [2:0] op, input logic [7:0] d, input logic a,
                          input int p, input int pAfter,
                          output int cyc, output bit busyOk, output bit pulseOk);
    @(negedge clk);
    base = rises;
    cmdOp = op; cmdData = d; cmdAck = a; prescale = PW'(p); cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    prescale = PW'(pAfter);
    cyc = 1;
    busyOk = (op > 3'd4) || !cmdReady;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    pulseOk = cmdReady;
    @(negedge clk);
    pulseOk = pulseOk && !done;
  endtask

  task automatic testResetState();
    check(sclOut == 1'b1,      "R1 scl", sclOut, 1);
    check(sdaDriveLow == 1'b0, "R1 sda", sdaDriveLow, 0);
    check(cmdReady == 1'b1,    "R1 ready", cmdReady, 1);
    check(done == 1'b0,        "R1 done", done, 0);
    check(ackBit == 1'b1,      "R1 ack", ackBit, 1);
  endtask

  task automatic testBusReset();
    int cyc; bit b, pl; int st;
    st = stops;
    issueCmd(3'd0, 8'h00, 1'b0, 1, 1, cyc, b, pl);
    check(cyc == 40*2+1, "R9 duration", cyc, 81);
    check(rises - base == 10, "R9 rises", rises - base, 10);
    check(capShift[9:0] == 10'b1111111110, "R9 sda released", capShift[9:0], 10'h3FE);
    check(lastHi == 4, "R9 high phase", lastHi, 4);
    check(stops == st + 1, "R4 stop after recovery", stops - st, 1);
    check(sdaDriveLow == 1'b0 && sclOut == 1'b1, "R9 end state", {sclOut, sdaDriveLow}, 2);
    check(b && pl, "R2 handshake", {b, pl}, 3);
  endtask

  task automatic testStart(input int p);
    int cyc; bit b, pl; int s0;
    s0 = starts;
    issueCmd(3'd1, 8'h00, 1'b0, p, p, cyc, b, pl);
    check(cyc == 4*(p+1)+1, "R3 duration", cyc, 4*(p+1)+1);
    check(starts == s0 + 1, "R3 start seen", starts - s0, 1);
    check(sclOut == 1'b1 && sdaBus == 1'b0, "R3 end state", {sclOut, sdaBus}, 2);
    check(b && pl, "R2 handshake", {b, pl}, 3);
  endtask

  task automatic testWrite(input logic [7:0] d, input logic ackEn, input int p);
    int cyc; bit b, pl;
    slaveAckEn = ackEn; slaveMode = 1;
    issueCmd(3'd3, d, 1'b0, p, p, cyc, b, pl);
    slaveMode = 0;
    check(cyc == 37*(p+1)+1, "R5 duration", cyc, 37*(p+1)+1);
    check(capShift[8:1] == d, "R5 bits on bus", capShift[8:1], d);
    check(lastHi == 2*(p+1), "R5 high phase", lastHi, 2*(p+1));
    check(ackBit == !ackEn, "R6 ack bit", ackBit, !ackEn);
    check(b && pl, "R2 handshake", {b, pl}, 3);
  endtask

  task automatic testRead(input logic [7:0] d, input logic a, input int p);
    int cyc; bit b, pl;
    slaveData = d; slaveMode = 2;
    @(negedge clk);
    slaveLow = ~d[7];
    issueCmd(3'd4, 8'h00, a, p, p, cyc, b, pl);
    slaveMode = 0;
    check(cyc == 29*(p+1)+1, "R7 duration", cyc, 29*(p+1)+1);
    check(rxByte == d, "R7 received byte", rxByte, d);
    check(capShift[0] == a, "R8 ack level on bus", capShift[0], a);
    check(lastHi == 2*(p+1), "R8 ack high phase", lastHi, 2*(p+1));
  endtask

  task automatic testHold();
    int cyc; bit b, pl;
    logic [7:0] r0; logic a0;
    r0 = rxByte; a0 = ackBit;
    issueCmd(3'd1, 8'hFF, 1'b1, 0, 0, cyc, b, pl);
    check(rxByte == r0 && ackBit == a0, "R11 results held", {rxByte, ackBit}, {r0, a0});
  endtask

  task automatic testStopPrescale();
    int cyc; bit b, pl; int st;
    st = stops;
    issueCmd(3'd2, 8'h00, 1'b0, 3, 0, cyc, b, pl);
    check(cyc == 4*4+1, "R10 prescale captured", cyc, 17);
    check(stops == st + 1, "R4 stop seen", stops - st, 1);
    check(sclOut == 1'b1 && sdaDriveLow == 1'b0, "R4 end state", {sclOut, sdaDriveLow}, 2);
  endtask

  task automatic testUndefined();
    int cyc; bit b, pl; int r0;
    r0 = rises;
    issueCmd(3'd6, 8'h00, 1'b0, 5, 5, cyc, b, pl);
    check(cyc == 1, "R12 immediate done", cyc, 1);
    check(rises == r0 && sclOut == 1'b1 && sdaDriveLow == 1'b0, "R12 bus untouched",
          rises - r0, 0);
    check(pl, "R2 single pulse", pl, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R2 actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testResetState();
    testBusReset();
    testStart(0);
    testWrite(8'hA5, 1'b1, 2);
    testWrite(8'h3C, 1'b0, 0);
    testStart(1);
    testRead(8'h96, 1'b0, 1);
    testRead(8'h5B, 1'b1, 0);
    testHold();
    testStopPrescale();
    testUndefined();
    summary();
    $finish;
  end

endmodule